// File: doc/BRIEF.md
# I2C Message Sequencer

This block drives a byte-level I2C engine through a whole read or write message, so that software (or a higher controller) hands over one message description and receives one completion. The message description gives a 7-bit or 10-bit target address, a read/write direction, a flag that inverts the direction bit sent on the bus, a flag that skips the START and address phases, and a byte count. Write data comes in on a byte input that the sequencer consumes one byte at a time. Received bytes go out on a strobed byte output.

Each time the engine reports an event with its status code, the sequencer answers one cycle later with exactly one action. The possible actions are continue, START, first address byte, second address byte, send data, receive data, receive-and-STOP, or STOP. Along with the action it presents the acknowledge-enable and interrupt-enable control bits that the engine should use. The choice of action depends on the status code, the address mode and the number of bytes still to move. The acknowledge bit is dropped before the last byte of a read, so that byte is NACKed. An abort request turns the next engine event into a STOP. Every STOP ends with a completion pulse and a two-bit result code.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, busy, act_valid, done, tx_take, rx_valid, ack_en and irq_en are 0, and result is 0.
- R2: A 7-bit address is sent as one byte {addr[6:0], d}, where d = read XOR rev and read is 1 for a read.
- R3: In 10-bit mode the first address byte is 0xF0 | (addr[9:8] << 1) | d. The second byte is addr[7:0]. The second byte is sent as action ADDR2 on status 0x18 or 0x40.
- R4: start while idle (with no engine event in the same cycle) gives action START, sets busy, and sets ack_en and irq_en to 1. Action codes: CONTINUE=1, START=2, ADDR1=3, ADDR2=4, SEND=5, RECV=6, RECV_STOP=7, STOP=8.
- R5: Status 0x08 or 0x10 gives action ADDR1 carrying the first address byte.
- R6: In a write, status 0x18 (7-bit), 0xD0 or 0x28 with bytes remaining gives SEND carrying tx_data, pulses tx_take and decrements the count. With no bytes remaining it gives STOP with result 0.
- R7: In a read, status 0x40 (7-bit) or 0xE0 gives CONTINUE. Status 0x50 gives RECV with rx_byte equal to the engine byte and decrements the count. ack_en falls when the remaining count is one.
- R8: Status 0x58 gives RECV_STOP with the received byte, result 0, done, and a return to idle.
- R9: Status 0x20, 0x30 or 0x48 gives STOP with result 1 (no device). Any status not listed in R5 to R9 gives STOP with result 2 (I/O error).
- R10: abort_req while busy makes the next engine event give STOP with result 3.
- R11: An engine event while idle gives STOP and done, and leaves result unchanged. A start in that same cycle is ignored.
- R12: With the no-start flag set, a read launch gives CONTINUE and a write launch gives SEND of the first byte. Neither emits START.
- R13: A zero-length read gives STOP with result 0 on the address acknowledge.
- R14: Every STOP and RECV_STOP clears irq_en and pulses done. Every action appears one cycle after the event or start that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch a message (taken when idle) |
| cfg_addr | input | 10 | Target address |
| cfg_ten | input | 1 | 10-bit address mode |
| cfg_read | input | 1 | 1 = read message |
| cfg_rev | input | 1 | Invert the bus direction bit |
| cfg_nostart | input | 1 | Skip START and address phases |
| cfg_len | input | LEN_W | Byte count |
| abort_req | input | 1 | Request an abort of the running message |
| evt_valid | input | 1 | Engine event flag |
| evt_status | input | 8 | Engine status code |
| eng_rx_data | input | 8 | Byte received by the engine |
| tx_data | input | 8 | Next byte to write |
| tx_take | output | 1 | tx_data was consumed |
| act_valid | output | 1 | Action strobe |
| act_code | output | 4 | Action code |
| act_byte | output | 8 | Byte for the engine's data register |
| ack_en | output | 1 | Acknowledge enable |
| irq_en | output | 1 | Interrupt enable |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| done | output | 1 | Message completion pulse |
| result | output | 2 | 0 OK, 1 no device, 2 I/O error, 3 aborted |
| busy | output | 1 | Message in progress |

## Verification
A corrupted phase state or byte count shows up at the ports on the very next engine event, as the wrong action code. Typical symptoms are a SEND where a STOP belongs, a missing ADDR2, or a read that ends one byte early or late. A miscounted read also shows as ack_en falling at the wrong byte, one cycle after the receive status. A lost abort or error classification appears as a wrong result code on the cycle that done pulses.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

    typedef enum logic [3:0] {
        ACT_NONE      = 4'd0,
        ACT_CONTINUE  = 4'd1,
        ACT_START     = 4'd2,
        ACT_ADDR1     = 4'd3,
        ACT_ADDR2     = 4'd4,
        ACT_SEND      = 4'd5,
        ACT_RECV      = 4'd6,
        ACT_RECV_STOP = 4'd7,
        ACT_STOP      = 4'd8
    } act_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_WAIT_START, PH_WAIT_A1, PH_WAIT_A2,
        PH_WAIT_TXACK, PH_WAIT_RXDATA, PH_ABORT
    } phase_e;

    typedef enum logic [3:0] {
        EV_START, EV_WADDR, EV_RADDR, EV_WADDR2, EV_RADDR2,
        EV_WDATA, EV_RDATA_ACK, EV_RDATA_NACK, EV_NODEV, EV_OTHER
    } evclass_e;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_NODEV = 2'd1;
    localparam logic [1:0] RES_IOERR = 2'd2;
    localparam logic [1:0] RES_ABORT = 2'd3;

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr (
    input  logic [9:0] addr,
    input  logic       ten,
    input  logic       read,
    input  logic       rev,
    output logic [7:0] first_byte,
    output logic [7:0] second_byte
);
    logic dir;

    always_comb begin
        dir = read ^ rev;
        if (ten) begin
            first_byte  = {5'b11110, addr[9:8], dir};
            second_byte = addr[7:0];
        end else begin
            first_byte  = {addr[6:0], dir};
            second_byte = 8'h00;
        end
    end
endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
    import i2c_msg_seq_pkg::*;
(
    input  logic [7:0] status,
    output evclass_e   cls
);
    always_comb begin
        unique case (status)
            8'h08, 8'h10:         cls = EV_START;
            8'h18:                cls = EV_WADDR;
            8'h40:                cls = EV_RADDR;
            8'hD0:                cls = EV_WADDR2;
            8'hE0:                cls = EV_RADDR2;
            8'h28:                cls = EV_WDATA;
            8'h50:                cls = EV_RDATA_ACK;
            8'h58:                cls = EV_RDATA_NACK;
            8'h20, 8'h30, 8'h48:  cls = EV_NODEV;
            default:              cls = EV_OTHER;
        endcase
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_msg_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [9:0]       cfg_addr,
    input  logic             cfg_ten,
    input  logic             cfg_read,
    input  logic             cfg_rev,
    input  logic             cfg_nostart,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             abort_req,
    input  logic             evt_valid,
    input  logic [7:0]       evt_status,
    input  logic [7:0]       eng_rx_data,
    input  logic [7:0]       tx_data,
    output logic             tx_take,
    output logic             act_valid,
    output logic [3:0]       act_code,
    output logic [7:0]       act_byte,
    output logic             ack_en,
    output logic             irq_en,
    output logic             rx_valid,
    output logic [7:0]       rx_byte,
    output logic             done,
    output logic [1:0]       result,
    output logic             busy
);
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic             ten;
        logic [7:0]       a1;
        logic [7:0]       a2;
        logic [LEN_W-1:0] left;
        logic             ack;
        logic             irq;
        logic             av;
        act_e             code;
        logic [7:0]       abyte;
        logic             take;
        logic             rxv;
        logic [7:0]       rxb;
        logic             done;
        logic [1:0]       res;
    } seq_t;

    seq_t     s_d, s_q;
    logic [7:0] first_b, second_b;
    evclass_e cls;
    logic     aborting, do_stop, keep_res;
    logic [1:0] stop_res;

    i2c_seq_addr u_addr (
        .addr(cfg_addr), .ten(cfg_ten), .read(cfg_read), .rev(cfg_rev),
        .first_byte(first_b), .second_byte(second_b)
    );

    i2c_seq_decode u_dec (.status(evt_status), .cls(cls));

    always_comb begin
        s_d       = s_q;
        s_d.av    = 1'b0;
        s_d.code  = ACT_NONE;
        s_d.abyte = 8'h00;
        s_d.take  = 1'b0;
        s_d.rxv   = 1'b0;
        s_d.done  = 1'b0;
        do_stop   = 1'b0;
        keep_res  = 1'b0;
        stop_res  = RES_OK;
        aborting  = (s_q.phase == PH_ABORT) || abort_req;

        if (s_q.phase == PH_IDLE) begin
            if (evt_valid) begin
                do_stop  = 1'b1;
                keep_res = 1'b1;
            end else if (start) begin
                s_d.ten  = cfg_ten;
                s_d.a1   = first_b;
                s_d.a2   = second_b;
                s_d.left = cfg_len;
                s_d.ack  = 1'b1;
                s_d.irq  = 1'b1;
                s_d.av   = 1'b1;
                if (!cfg_nostart) begin
                    s_d.code  = ACT_START;
                    s_d.phase = PH_WAIT_START;
                end else if (cfg_read) begin
                    s_d.code  = ACT_CONTINUE;
                    s_d.phase = PH_WAIT_RXDATA;
                end else if (cfg_len == '0) begin
                    do_stop = 1'b1;
                end else begin
                    s_d.code  = ACT_SEND;
                    s_d.abyte = tx_data;
                    s_d.take  = 1'b1;
                    s_d.left  = cfg_len - CNT_ONE;
                    s_d.phase = PH_WAIT_TXACK;
                end
            end
        end else if (evt_valid) begin
            s_d.av = 1'b1;
            if (aborting) begin
                do_stop  = 1'b1;
                stop_res = RES_ABORT;
            end else begin
                unique case (cls)
                    EV_START: begin
                        s_d.code  = ACT_ADDR1;
                        s_d.abyte = s_q.a1;
                        s_d.phase = PH_WAIT_A1;
                    end
                    EV_WADDR, EV_RADDR, EV_WADDR2, EV_RADDR2, EV_WDATA: begin
                        if (s_q.ten && (cls == EV_WADDR || cls == EV_RADDR)) begin
                            s_d.code  = ACT_ADDR2;
                            s_d.abyte = s_q.a2;
                            s_d.phase = PH_WAIT_A2;
                        end else if (s_q.left == '0) begin
                            do_stop = 1'b1;
                        end else if (cls == EV_RADDR || cls == EV_RADDR2) begin
                            s_d.code  = ACT_CONTINUE;
                            s_d.phase = PH_WAIT_RXDATA;
                            if (s_q.left == CNT_ONE) s_d.ack = 1'b0;
                        end else begin
                            s_d.code  = ACT_SEND;
                            s_d.abyte = tx_data;
                            s_d.take  = 1'b1;
                            s_d.left  = s_q.left - CNT_ONE;
                            s_d.phase = PH_WAIT_TXACK;
                        end
                    end
                    EV_RDATA_ACK: begin
                        s_d.code  = ACT_RECV;
                        s_d.rxv   = 1'b1;
                        s_d.rxb   = eng_rx_data;
                        s_d.phase = PH_WAIT_RXDATA;
                        if (s_q.left != '0) s_d.left = s_q.left - CNT_ONE;
                        if (s_q.left == LEN_W'(2)) s_d.ack = 1'b0;
                    end
                    EV_RDATA_NACK: begin
                        s_d.rxv = 1'b1;
                        s_d.rxb = eng_rx_data;
                        do_stop = 1'b1;
                    end
                    EV_NODEV: begin
                        do_stop  = 1'b1;
                        stop_res = RES_NODEV;
                    end
                    default: begin
                        do_stop  = 1'b1;
                        stop_res = RES_IOERR;
                    end
                endcase
            end
        end else if (abort_req) begin
            s_d.phase = PH_ABORT;
        end

        if (do_stop) begin
            s_d.av    = 1'b1;
            s_d.code  = (evt_valid && cls == EV_RDATA_NACK && s_q.phase != PH_IDLE
                         && !aborting) ? ACT_RECV_STOP : ACT_STOP;
            s_d.abyte = 8'h00;
            s_d.irq   = 1'b0;
            s_d.done  = 1'b1;
            s_d.phase = PH_IDLE;
            if (!keep_res) s_d.res = stop_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.code  <= ACT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_take   = s_q.take;
    assign act_valid = s_q.av;
    assign act_code  = s_q.code;
    assign act_byte  = s_q.abyte;
    assign ack_en    = s_q.ack;
    assign irq_en    = s_q.irq;
    assign rx_valid  = s_q.rxv;
    assign rx_byte   = s_q.rxb;
    assign done      = s_q.done;
    assign result    = s_q.res;
    assign busy      = (s_q.phase != PH_IDLE);
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk
    import i2c_msg_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       evt_valid,
    input logic       busy,
    input logic       act_valid,
    input logic [3:0] act_code,
    input logic       done,
    input logic       irq_en,
    input logic       rx_valid,
    input logic       tx_take
);
    // R14: completion comes only with a stop-type action and interrupts off
    p_done_is_stop_r14: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act_valid && !irq_en &&
                  (act_code == ACT_STOP || act_code == ACT_RECV_STOP)));

    // R14: every action follows an event or a launch one cycle earlier
    p_action_cause_r14: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> $past(evt_valid || start));

    // R7: a received byte goes out only with a receive action
    p_rx_with_recv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (act_valid &&
                      (act_code == ACT_RECV || act_code == ACT_RECV_STOP)));

    // R6: a write byte is consumed only by a send action
    p_take_with_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (act_valid && act_code == ACT_SEND));

    // R8: completion leaves the sequencer idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: a clean launch from idle makes the sequencer busy
    p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !evt_valid) |=> busy);
endmodule

bind i2c_msg_seq i2c_msg_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .evt_valid(evt_valid),
    .busy(busy), .act_valid(act_valid), .act_code(act_code), .done(done),
    .irq_en(irq_en), .rx_valid(rx_valid), .tx_take(tx_take)
);

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] cfg_addr = '0;
    logic       cfg_ten = 1'b0, cfg_read = 1'b0, cfg_rev = 1'b0, cfg_nostart = 1'b0;
    logic [7:0] cfg_len = '0;
    logic       abort_req = 1'b0, evt_valid = 1'b0;
    logic [7:0] evt_status = '0, eng_rx_data = '0, tx_data = '0;
    logic       tx_take, act_valid, ack_en, irq_en, rx_valid, done, busy;
    logic [3:0] act_code;
    logic [7:0] act_byte, rx_byte;
    logic [1:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    i2c_msg_seq #(.LEN_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
        .cfg_ten(cfg_ten), .cfg_read(cfg_read), .cfg_rev(cfg_rev),
        .cfg_nostart(cfg_nostart), .cfg_len(cfg_len), .abort_req(abort_req),
        .evt_valid(evt_valid), .evt_status(evt_status), .eng_rx_data(eng_rx_data),
        .tx_data(tx_data), .tx_take(tx_take), .act_valid(act_valid),
        .act_code(act_code), .act_byte(act_byte), .ack_en(ack_en),
        .irq_en(irq_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .done(done), .result(result), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [9:0] a, input logic ten, input logic rd,
                          input logic rv, input logic ns, input logic [7:0] len);
        @(negedge clk);
        cfg_addr = a; cfg_ten = ten; cfg_read = rd; cfg_rev = rv;
        cfg_nostart = ns; cfg_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic ev(input logic [7:0] st, input logic [7:0] rxb);
        @(negedge clk);
        evt_valid = 1'b1; evt_status = st; eng_rx_data = rxb;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 act_valid", act_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 ack_en", ack_en, 0);
        chk("R1 irq_en", irq_en, 0);
        chk("R1 result", result, 0);
        chk("R1 tx_take", tx_take, 0);
    endtask

    task automatic t_write7();
        launch(10'h050, 0, 0, 0, 0, 8'd2);
        chk("R4 start code", act_code, 2);
        chk("R4 busy", busy, 1);
        chk("R4 ack_en", ack_en, 1);
        chk("R4 irq_en", irq_en, 1);
        ev(8'h08, 0);
        chk("R5 addr1 code", act_code, 3);
        chk("R2 addr byte", act_byte, 8'hA0);
        tx_data = 8'h5A;
        ev(8'h18, 0);
        chk("R6 send code", act_code, 5);
        chk("R6 send byte", act_byte, 8'h5A);
        chk("R6 take", tx_take, 1);
        tx_data = 8'hC3;
        ev(8'h28, 0);
        chk("R6 second byte", act_byte, 8'hC3);
        ev(8'h28, 0);
        chk("R6 stop code", act_code, 8);
        chk("R14 done", done, 1);
        chk("R14 irq_en off", irq_en, 0);
        chk("R6 result", result, 0);
        chk("R6 idle", busy, 0);
    endtask

    task automatic t_read7();
        launch(10'h050, 0, 1, 0, 0, 8'd3);
        ev(8'h10, 0);
        chk("R2 read addr", act_byte, 8'hA1);
        ev(8'h40, 0);
        chk("R7 continue", act_code, 1);
        chk("R7 ack held", ack_en, 1);
        ev(8'h50, 8'h11);
        chk("R7 recv code", act_code, 6);
        chk("R7 rx byte", rx_byte, 8'h11);
        chk("R7 rx valid", rx_valid, 1);
        chk("R7 ack still on", ack_en, 1);
        ev(8'h50, 8'h22);
        chk("R7 ack dropped", ack_en, 0);
        ev(8'h58, 8'h33);
        chk("R8 recv_stop", act_code, 7);
        chk("R8 last byte", rx_byte, 8'h33);
        chk("R8 done", done, 1);
        chk("R8 result", result, 0);
        chk("R8 idle", busy, 0);
    endtask

    task automatic t_ten();
        launch(10'h2A5, 1, 0, 1, 0, 8'd1);
        ev(8'h08, 0);
        chk("R3 first byte", act_byte, 8'hF5);
        ev(8'h18, 0);
        chk("R3 addr2 code", act_code, 4);
        chk("R3 second byte", act_byte, 8'hA5);
        tx_data = 8'h77;
        ev(8'hD0, 0);
        chk("R6 send after addr2", act_code, 5);
        ev(8'h30, 0);
        chk("R9 nodev code", act_code, 8);
        chk("R9 nodev result", result, 1);
    endtask

    task automatic t_errors();
        launch(10'h013, 0, 0, 0, 0, 8'd1);
        ev(8'h38, 0);
        chk("R9 ioerr code", act_code, 8);
        chk("R9 ioerr result", result, 2);
        launch(10'h013, 0, 1, 0, 0, 8'd1);
        ev(8'h08, 0);
        ev(8'h48, 0);
        chk("R9 read nodev", result, 1);
    endtask

    task automatic t_abort();
        launch(10'h013, 0, 0, 0, 0, 8'd4);
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        chk("R10 no action yet", act_valid, 0);
        ev(8'h08, 0);
        chk("R10 stop code", act_code, 8);
        chk("R10 result", result, 3);
        chk("R10 done", done, 1);
    endtask

    task automatic t_stray();
        @(negedge clk);
        evt_valid = 1'b1; evt_status = 8'h28; start = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; start = 1'b0;
        chk("R11 stop code", act_code, 8);
        chk("R11 done", done, 1);
        chk("R11 result kept", result, 3);
        chk("R11 start ignored", busy, 0);
    endtask

    task automatic t_nostart();
        launch(10'h013, 0, 1, 0, 1, 8'd1);
        chk("R12 read continue", act_code, 1);
        ev(8'h58, 8'h9C);
        chk("R12 read byte", rx_byte, 8'h9C);
        tx_data = 8'hE1;
        launch(10'h013, 0, 0, 0, 1, 8'd1);
        chk("R12 write send", act_code, 5);
        chk("R12 write byte", act_byte, 8'hE1);
        ev(8'h28, 0);
        chk("R12 write stop", act_code, 8);
    endtask

    task automatic t_zero_read();
        launch(10'h013, 0, 1, 0, 0, 8'd0);
        ev(8'h08, 0);
        ev(8'h40, 0);
        chk("R13 stop code", act_code, 8);
        chk("R13 result", result, 0);
        chk("R13 done", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write7();
        t_read7();
        t_ten();
        t_errors();
        t_abort();
        t_stray();
        t_nostart();
        t_zero_read();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule